// File: doc/BRIEF.md
# DMA Burst Transfer Engine with Peripheral Handshake

This block moves data for one DMA channel at a time. The arbiter grants it a channel by handing over a command word, a source address, a destination address and a beat count. The engine decodes the command into a beat width, a burst length and a separate address step for each side. It then moves data in bursts over a single-outstanding memory master port. Each burst reads all of its beats into a small local buffer and then writes them out. Before each burst the engine checks the peripheral request lines selected by the command, and it raises the matching acknowledge lines as each phase finishes.

The engine hands the channel back with a one-cycle return strobe, carrying the updated command, addresses and count. This happens in two cases. The first is that the count has reached zero: the start bit is then cleared and the finish flag is set if the command enables it. The second is that a selected request line is low at a burst boundary: the channel is then returned with all progress so far kept, so the arbiter can grant it again later.

Top module: `dme_xfer_engine`

## Requirements
- R1: Command bits 21:20 select the beat width for both sides: code 0 is 32-bit, code 1 is 16-bit, and codes 2 and 3 are 8-bit. Every bus beat reports this width on `mem_size_o`, encoded 2 = 32-bit, 1 = 16-bit, 0 = 8-bit.
- R2: Command bits 9:8 give the source step code and bits 13:12 give the destination step code. Code 0 keeps the address fixed. Codes 1, 2 and 3 advance the address by 1, 2 and 4 times the beat size in bytes after each beat on that side.
- R3: With command bit 3 set, a burst is four beats; with it clear, a burst is one beat. The last burst is shortened to the remaining count.
- R4: Each burst issues all of its reads before any of its writes. The k-th write of a burst carries the full 32-bit word returned by the k-th read of that burst.
- R5: Command bits 27:24 name the source request line and bits 19:16 name the destination request line; ID 0 means no handshake on that side. A burst starts only if every named line is high. Otherwise the engine returns the channel with no bus beat, and with the command, addresses and count unchanged.
- R6: The acknowledge for the source line rises after the last read of a burst, and the acknowledge for the destination line rises after the last write. An acknowledge falls one cycle after its request line is low. Acknowledge line 0 is never driven.
- R7: After each burst the count drops by the number of beats moved. When it reaches zero, the returned command has bit 0 cleared and bit 1 set if bit 2 is set. The returned addresses point one step past the last beat on each side.
- R8: A channel granted with a count of zero is returned finished (as in R7) with no bus beat.
- R9: While `mem_req_o` is high and `mem_ready_i` is low, the request, direction, address and write data stay unchanged.
- R10: After reset the engine is idle: `busy_o`, `mem_req_o`, `ret_valid_o` and all acknowledges are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go_i | input | 1 | Grant strobe, sampled only while idle |
| cmd_i | input | 32 | Channel command word |
| src_i | input | ADDR_W | Channel source address |
| dst_i | input | ADDR_W | Channel destination address |
| cnt_i | input | CNT_W | Remaining beat count |
| busy_o | output | 1 | Engine holds a channel |
| ret_valid_o | output | 1 | One-cycle strobe: returned channel state is valid |
| ret_cmd_o | output | 32 | Returned command word |
| ret_src_o | output | ADDR_W | Returned source address |
| ret_dst_o | output | ADDR_W | Returned destination address |
| ret_cnt_o | output | CNT_W | Returned count |
| mem_req_o | output | 1 | Bus beat request |
| mem_we_o | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr_o | output | ADDR_W | Beat address |
| mem_size_o | output | 2 | Beat width code |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid with ready on a read beat |
| mem_ready_i | input | 1 | Beat completes in this cycle |
| hs_req_i | input | 2**HS_ID_W | Peripheral request lines |
| hs_ack_o | output | 2**HS_ID_W | Peripheral acknowledge lines |

## Verification
The assertions assume that a granted channel has its start bit set, so that a return with start cleared can only mean a finished count. They also assume that `go_i` rises only while `busy_o` is low. The stimulus always sets bit 0 in the commands it issues and waits for each return before the next grant. Request lines stay steady during a transfer, except in the directed stall and release cases, which change them only while the engine is idle. Ready is random, so the hold rule on the bus is exercised with wait states of varying length.

// File: rtl/dme_pkg.sv
package dme_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } dme_state_e;

    // bus width codes on mem_size_o
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/dme_cmd_decode.sv
module dme_cmd_decode #(
    parameter int ADDR_W    = 32,
    parameter int BURST_LEN = 4,
    localparam int BW       = $clog2(BURST_LEN + 1)
) (
    input  logic [1:0]        width_code_i,
    input  logic [1:0]        src_step_code_i,
    input  logic [1:0]        dst_step_code_i,
    input  logic              burst_en_i,
    output logic [1:0]        size_o,
    output logic [ADDR_W-1:0] src_step_o,
    output logic [ADDR_W-1:0] dst_step_o,
    output logic [BW-1:0]     burst_len_o
);
    import dme_pkg::*;

    logic [ADDR_W-1:0] bytes;

    always_comb begin
        case (width_code_i)
            2'd0:    begin size_o = SZ_WORD; bytes = ADDR_W'(4); end
            2'd1:    begin size_o = SZ_HALF; bytes = ADDR_W'(2); end
            default: begin size_o = SZ_BYTE; bytes = ADDR_W'(1); end
        endcase
    end

    function automatic logic [ADDR_W-1:0] step_of(input logic [1:0] code,
                                                  input logic [ADDR_W-1:0] b);
        case (code)
            2'd0:    step_of = '0;
            2'd1:    step_of = b;
            2'd2:    step_of = b << 1;
            default: step_of = b << 2;
        endcase
    endfunction

    assign src_step_o  = step_of(src_step_code_i, bytes);
    assign dst_step_o  = step_of(dst_step_code_i, bytes);
    assign burst_len_o = burst_en_i ? BW'(BURST_LEN) : BW'(1);
endmodule

// File: rtl/dme_handshake.sv
module dme_handshake #(
    parameter int HS_ID_W  = 4,
    localparam int LINES   = 1 << HS_ID_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINES-1:0]   req_i,
    input  logic [HS_ID_W-1:0] src_id_i,
    input  logic [HS_ID_W-1:0] dst_id_i,
    input  logic               set_src_i,
    input  logic               set_dst_i,
    output logic               ok_o,
    output logic [LINES-1:0]   ack_o
);
    logic src_ok, dst_ok;

    assign src_ok = (src_id_i == '0) || req_i[src_id_i];
    assign dst_ok = (dst_id_i == '0) || req_i[dst_id_i];
    assign ok_o   = src_ok && dst_ok;

    assign ack_o[0] = 1'b0;

    for (genvar i = 1; i < LINES; i++) begin : g_line
        logic ack_d, ack_q;
        always_comb begin
            ack_d = ack_q;
            if ((set_src_i && src_id_i == HS_ID_W'(i)) ||
                (set_dst_i && dst_id_i == HS_ID_W'(i)))
                ack_d = 1'b1;
            if (!req_i[i])
                ack_d = 1'b0;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ack_q <= 1'b0;
            else        ack_q <= ack_d;
        end
        assign ack_o[i] = ack_q;
    end
endmodule

// File: rtl/dme_burst_buf.sv
module dme_burst_buf #(
    parameter int DATA_W   = 32,
    parameter int DEPTH    = 4,
    localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [DATA_W-1:0] entry [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        logic [DATA_W-1:0] ent_d, ent_q;
        always_comb begin
            ent_d = ent_q;
            if (wr_en_i && wr_idx_i == IDX_W'(i))
                ent_d = wr_data_i;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end
        assign entry[i] = ent_q;
    end

    assign rd_data_o = entry[rd_idx_i];
endmodule

// File: rtl/dme_xfer_engine.sv
module dme_xfer_engine #(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 24,
    parameter int BURST_LEN = 4,
    parameter int HS_ID_W   = 4,
    localparam int LINES    = 1 << HS_ID_W,
    localparam int BW       = $clog2(BURST_LEN + 1),
    localparam int IDX_W    = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [31:0]       cmd_i,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              busy_o,
    output logic              ret_valid_o,
    output logic [31:0]       ret_cmd_o,
    output logic [ADDR_W-1:0] ret_src_o,
    output logic [ADDR_W-1:0] ret_dst_o,
    output logic [CNT_W-1:0]  ret_cnt_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [1:0]        mem_size_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_ready_i,
    input  logic [LINES-1:0]  hs_req_i,
    output logic [LINES-1:0]  hs_ack_o
);
    import dme_pkg::*;

    // command field positions
    localparam int B_START  = 0;
    localparam int B_FIN    = 1;
    localparam int B_FIN_EN = 2;
    localparam int B_BURST  = 3;

    typedef struct packed {
        dme_state_e        st;
        logic [31:0]       cmd;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        logic [BW-1:0]     beat;
        logic [BW-1:0]     nbeats;
        logic              ret;
    } eng_t;

    eng_t q, d;

    logic [1:0]        size;
    logic [ADDR_W-1:0] src_step, dst_step;
    logic [BW-1:0]     burst_len;
    logic              hs_ok, set_src, set_dst, buf_we;
    logic              last_beat;

    dme_cmd_decode #(.ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN)) u_dec (
        .width_code_i   (q.cmd[21:20]),
        .src_step_code_i(q.cmd[9:8]),
        .dst_step_code_i(q.cmd[13:12]),
        .burst_en_i     (q.cmd[B_BURST]),
        .size_o         (size),
        .src_step_o     (src_step),
        .dst_step_o     (dst_step),
        .burst_len_o    (burst_len)
    );

    dme_handshake #(.HS_ID_W(HS_ID_W)) u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (hs_req_i),
        .src_id_i (q.cmd[24 +: HS_ID_W]),
        .dst_id_i (q.cmd[16 +: HS_ID_W]),
        .set_src_i(set_src),
        .set_dst_i(set_dst),
        .ok_o     (hs_ok),
        .ack_o    (hs_ack_o)
    );

    dme_burst_buf #(.DATA_W(DATA_W), .DEPTH(BURST_LEN)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (buf_we),
        .wr_idx_i (q.beat[IDX_W-1:0]),
        .wr_data_i(mem_rdata_i),
        .rd_idx_i (q.beat[IDX_W-1:0]),
        .rd_data_o(mem_wdata_o)
    );

    assign last_beat = (q.beat == q.nbeats - BW'(1));

    always_comb begin
        d       = q;
        d.ret   = 1'b0;
        buf_we  = 1'b0;
        set_src = 1'b0;
        set_dst = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (go_i) begin
                    d.cmd = cmd_i;
                    d.src = src_i;
                    d.dst = dst_i;
                    d.cnt = cnt_i;
                    d.st  = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (q.cnt == '0) begin
                    d.cmd[B_START] = 1'b0;
                    if (q.cmd[B_FIN_EN]) d.cmd[B_FIN] = 1'b1;
                    d.ret = 1'b1;
                    d.st  = ST_IDLE;
                end else if (!hs_ok) begin
                    d.ret = 1'b1;
                    d.st  = ST_IDLE;
                end else begin
                    d.nbeats = (q.cnt < CNT_W'(burst_len)) ? BW'(q.cnt) : burst_len;
                    d.beat   = '0;
                    d.st     = ST_READ;
                end
            end
            ST_READ: begin
                if (mem_ready_i) begin
                    buf_we = 1'b1;
                    d.src  = q.src + src_step;
                    if (last_beat) begin
                        d.beat  = '0;
                        d.st    = ST_WRITE;
                        set_src = 1'b1;
                    end else begin
                        d.beat = q.beat + BW'(1);
                    end
                end
            end
            default: begin
                if (mem_ready_i) begin
                    d.dst = q.dst + dst_step;
                    if (last_beat) begin
                        d.cnt   = q.cnt - CNT_W'(q.nbeats);
                        d.beat  = '0;
                        d.st    = ST_CHECK;
                        set_dst = 1'b1;
                    end else begin
                        d.beat = q.beat + BW'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy_o      = (q.st != ST_IDLE);
    assign ret_valid_o = q.ret;
    assign ret_cmd_o   = q.cmd;
    assign ret_src_o   = q.src;
    assign ret_dst_o   = q.dst;
    assign ret_cnt_o   = q.cnt;
    assign mem_req_o   = (q.st == ST_READ) || (q.st == ST_WRITE);
    assign mem_we_o    = (q.st == ST_WRITE);
    assign mem_addr_o  = (q.st == ST_WRITE) ? q.dst : q.src;
    assign mem_size_o  = size;
endmodule

// File: rtl/dme_xfer_engine_chk.sv
module dme_xfer_engine_chk #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int CW    = 24,
    parameter int LINES = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_o,
    input logic             ret_valid_o,
    input logic [31:0]      ret_cmd_o,
    input logic [CW-1:0]    ret_cnt_o,
    input logic             mem_req_o,
    input logic             mem_we_o,
    input logic [AW-1:0]    mem_addr_o,
    input logic [1:0]       mem_size_o,
    input logic [DW-1:0]    mem_wdata_o,
    input logic             mem_ready_i,
    input logic [LINES-1:0] hs_req_i,
    input logic [LINES-1:0] hs_ack_o
);
    AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_we_o) &&
        $stable(mem_addr_o) && (!mem_we_o || $stable(mem_wdata_o)))); // R9

    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_size_o != 2'd3)); // R1

    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((hs_ack_o & ~$past(hs_req_i)) == '0)); // R6

    AST_FINISH_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid_o && !ret_cmd_o[0]) |-> (ret_cnt_o == '0)); // R7

    AST_RET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid_o |-> (!busy_o && !mem_req_o)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o); // R10
endmodule

bind dme_xfer_engine dme_xfer_engine_chk #(
    .AW(ADDR_W), .DW(DATA_W), .CW(CNT_W), .LINES(LINES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .ret_valid_o(ret_valid_o),
    .ret_cmd_o  (ret_cmd_o),
    .ret_cnt_o  (ret_cnt_o),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_size_o (mem_size_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_ready_i(mem_ready_i),
    .hs_req_i   (hs_req_i),
    .hs_ack_o   (hs_ack_o)
);

// File: tb/sim_dme_xfer_engine.sv
module sim_dme_xfer_engine;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go_i = 1'b0;
    logic [31:0] cmd_i = '0, src_i = '0, dst_i = '0;
    logic [23:0] cnt_i = '0;
    logic        busy_o, ret_valid_o;
    logic [31:0] ret_cmd_o, ret_src_o, ret_dst_o;
    logic [23:0] ret_cnt_o;
    logic        mem_req_o, mem_we_o, mem_ready_i = 1'b0;
    logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic [1:0]  mem_size_o;
    logic [15:0] hs_req_i = '0, hs_ack_o;

    int nchk = 0, nerr = 0;
    bit rdy_rand = 1'b1;

    logic        lg_we   [256];
    logic [31:0] lg_addr [256];
    logic [31:0] lg_data [256];
    logic [1:0]  lg_size [256];
    int          nlog = 0;

    always #(CLK_NS/2) clk = ~clk;

    dme_xfer_engine u0 (.*);

    function automatic logic [31:0] rd_val(input logic [31:0] a);
        return {~a[15:0], a[15:0]} ^ 32'h1357_9bdf;
    endfunction

    assign mem_rdata_i = rd_val(mem_addr_o);

    always @(negedge clk) mem_ready_i <= rdy_rand ? ($urandom % 3 != 0) : 1'b1;

    always @(posedge clk) begin
        if (mem_req_o && mem_ready_i && nlog < 256) begin
            lg_we[nlog]   <= mem_we_o;
            lg_addr[nlog] <= mem_addr_o;
            lg_data[nlog] <= mem_wdata_o;
            lg_size[nlog] <= mem_size_o;
            nlog <= nlog + 1;
        end
    end

    task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    function automatic int bytes_of(input logic [31:0] c);
        return (c[21:20] == 2'd0) ? 4 : (c[21:20] == 2'd1) ? 2 : 1;
    endfunction
    function automatic logic [1:0] size_of(input logic [31:0] c);
        return (c[21:20] == 2'd0) ? 2'd2 : (c[21:20] == 2'd1) ? 2'd1 : 2'd0;
    endfunction
    function automatic logic [31:0] step_of(input logic [1:0] code, input int b);
        return (code == 0) ? 32'd0 : (code == 1) ? b : (code == 2) ? 2*b : 4*b;
    endfunction

    // grant one channel and compare everything it does
    task automatic run_xfer(input logic [31:0] c, input logic [31:0] s, input logic [31:0] dd,
                            input logic [23:0] n, input bit stall);
        int guard = 0;
        int b, k, p;
        logic [31:0] ss, ds, ec;
        @(negedge clk);
        nlog = 0;
        cmd_i = c; src_i = s; dst_i = dd; cnt_i = n; go_i = 1'b1;
        @(negedge clk);
        go_i = 1'b0;
        while (!ret_valid_o && guard < 2000) begin @(negedge clk); guard++; end
        chk(ret_valid_o, "R7 return strobe", {31'd0, ret_valid_o}, 32'd1);
        ss = step_of(c[9:8], bytes_of(c));
        ds = step_of(c[13:12], bytes_of(c));
        if (stall) begin
            chk(nlog == 0, "R5 no beats on stall", nlog, 0);
            chk(ret_cmd_o == c, "R5 cmd kept", ret_cmd_o, c);
            chk(ret_src_o == s && ret_dst_o == dd, "R5 addr kept", ret_src_o, s);
            chk(ret_cnt_o == n, "R5 count kept", {8'd0, ret_cnt_o}, {8'd0, n});
            return;
        end
        b = c[3] ? 4 : 1;
        k = 0; p = 0;
        while (k < n) begin
            int m = (n - k < b) ? (n - k) : b;
            for (int j = 0; j < m; j++) begin
                logic [31:0] ea = s + (k + j) * ss;
                chk(lg_we[p] == 1'b0, "R4 read first", {31'd0, lg_we[p]}, 0);
                chk(lg_addr[p] == ea, "R2 read addr", lg_addr[p], ea);
                chk(lg_size[p] == size_of(c), "R1 size", {30'd0, lg_size[p]}, {30'd0, size_of(c)});
                p++;
            end
            for (int j = 0; j < m; j++) begin
                logic [31:0] ea = dd + (k + j) * ds;
                chk(lg_we[p] == 1'b1, "R3 burst write", {31'd0, lg_we[p]}, 1);
                chk(lg_addr[p] == ea, "R2 write addr", lg_addr[p], ea);
                chk(lg_data[p] == rd_val(s + (k + j) * ss), "R4 write data",
                    lg_data[p], rd_val(s + (k + j) * ss));
                p++;
            end
            k += m;
        end
        chk(nlog == p, "R8 beat total", nlog, p);
        ec = c & ~32'h1;
        if (c[2]) ec[1] = 1'b1;
        chk(ret_cmd_o == ec, "R7 finish cmd", ret_cmd_o, ec);
        chk(ret_cnt_o == 0, "R7 count zero", {8'd0, ret_cnt_o}, 0);
        chk(ret_src_o == s + n * ss, "R7 src end", ret_src_o, s + n * ss);
        chk(ret_dst_o == dd + n * ds, "R7 dst end", ret_dst_o, dd + n * ds);
        if (n != 0 && c[27:24] != 0 && hs_req_i[c[27:24]])
            chk(hs_ack_o[c[27:24]], "R6 src ack", {16'd0, hs_ack_o}, 32'd1 << c[27:24]);
        if (n != 0 && c[19:16] != 0 && hs_req_i[c[19:16]])
            chk(hs_ack_o[c[19:16]], "R6 dst ack", {16'd0, hs_ack_o}, 32'd1 << c[19:16]);
        chk(!hs_ack_o[0], "R6 line zero", {16'd0, hs_ack_o}, 0);
    endtask

    initial begin
        #(CLK_NS * 200000);
        nerr++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        chk(!busy_o && !mem_req_o && !ret_valid_o && hs_ack_o == 0, "R10 reset state",
            {busy_o, mem_req_o, ret_valid_o, 13'd0, hs_ack_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed: zero count, single beat, four-beat with short tail
        run_xfer(32'h0000_0005, 32'h100, 32'h200, 24'd0, 1'b0);          // R8
        run_xfer(32'h0000_1101, 32'h300, 32'h400, 24'd1, 1'b0);          // R2
        run_xfer(32'h0020_310D, 32'h500, 32'h600, 24'd6, 1'b0);          // R3 byte, tail 2
        run_xfer(32'h0010_2209, 32'h700, 32'h800, 24'd4, 1'b0);          // R1 half

        // stall: source line 5 named but low, then released
        hs_req_i = 16'hFFDF;
        run_xfer(32'h0503_110D, 32'h900, 32'hA00, 24'd5, 1'b1);          // R5
        hs_req_i = 16'hFFFF;
        run_xfer(32'h0503_110D, 32'h900, 32'hA00, 24'd5, 1'b0);          // R5 resume
        // ack drops once its request is low
        @(negedge clk);
        hs_req_i = 16'h0000;
        @(negedge clk);
        chk(hs_ack_o == 0, "R6 ack drop", {16'd0, hs_ack_o}, 0);
        hs_req_i = 16'hFFFF;

        for (int i = 0; i < 60; i++) begin
            logic [31:0] c;
            c = {4'd0, 4'($urandom), 2'd0, 2'($urandom), 4'($urandom),
                 2'd0, 2'($urandom), 2'd0, 2'($urandom), 4'd0,
                 1'($urandom), 1'($urandom), 2'b01};
            if ($urandom % 2) c[27:24] = 4'd0;
            if ($urandom % 2) c[19:16] = 4'd0;
            rdy_rand = (i % 5 != 0);
            run_xfer(c, {$urandom} & 32'hFFF0_0000, {$urandom} & 32'h000F_FF00,
                     24'($urandom % 10), 1'b0);
        end

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule